// File: doc/BRIEF.md
# Oversampling Serial Receiver with Line-Break Handling

This block receives asynchronous serial characters. It is driven by a clock enable that pulses at sixteen times the bit rate. The receive line first passes through a two-stage synchronizer. The receiver then waits for the idle-high line to drop, which marks the start of a character. It times every bit from that edge and samples each one in the middle of the bit. A frame is a start bit, eight data bits sent least significant first, an optional parity bit, and one stop bit.

A character whose stop bit reads high is written into the output data register, together with a one-cycle valid strobe. A character whose stop bit reads low is not written. This covers the line-break case, where the sender holds the line low. The receiver keeps running during a break and raises a sticky framing-error flag. When odd parity is in use, it also raises the parity-error flag. Firmware can then read the synchronized line level to confirm that the line is still held low. After any frame ends, the receiver waits to see the line high before it will accept a new start edge. A long break therefore produces exactly one error frame.

Top module: `uart_brk_rx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `rx_valid`, `rx_data`, `frame_err` and `parity_err` are all 0 and `rxd_level` is 1.
- R2: Timing starts from the tick on which the receiver first sees the line low while armed. That tick counts as the first. Each bit is sampled on the eighth tick of that bit. Data bits arrive least significant bit first. A frame with a high stop bit loads `rx_data` and pulses `rx_valid` for exactly one clock.
- R3: When `par_en` is 1, one parity bit follows the eighth data bit. With `par_odd` = 0, the XOR of the data and parity bits must be 0. With `par_odd` = 1, it must be 1. A mismatch sets `parity_err`, and the byte is still delivered when the stop bit is high.
- R4: A stop bit sampled low sets `frame_err`. That frame leaves `rx_data` unchanged and produces no `rx_valid` pulse.
- R5: Consider a line held low for longer than a frame. It ends exactly one frame: data all 0, `frame_err` set, and `parity_err` set only under odd parity. No further frame starts until the line has been seen high again.
- R6: `rxd_level` follows `rxd` through two register stages. It is 0 for as long as a break lasts.
- R7: `frame_err` and `parity_err` stay set until `err_clr` is high for a clock. If an error is detected in the same cycle as a clear, the flag is set.
- R8: If the line reads high when the start bit is sampled, the receiver abandons the frame without output or error and re-arms.
- R9: Once a break ends, the next well-formed frame is received normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Clock enable at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| par_en | input | 1 | 1 = parity bit present after the data |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| err_clr | input | 1 | Clears both sticky error flags |
| rx_data | output | 8 | Last byte received with a good stop bit |
| rx_valid | output | 1 | One-cycle strobe when rx_data is loaded |
| frame_err | output | 1 | Sticky: stop bit was sampled low |
| parity_err | output | 1 | Sticky: parity check failed |
| rxd_level | output | 1 | Synchronized level of rxd |

## Verification
The set of an error flag at the end of a frame can fall in the same cycle as a software clear. To provoke this, the bench holds `err_clr` high across an entire frame that carries a wrong parity bit. It latches any cycle in which `parity_err` reads high. The flag has to appear for that one cycle and then be cleared by the clear that is still asserted. A second collision is tested in a break: the line stays low after the framing error, and the bench clears the flag. The flag must not return, because the re-arm rule forbids a second frame.

// File: rtl/uart_brk_rx_pkg.sv
package uart_brk_rx_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_HI,
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic ferr;
        logic perr;
    } rx_status_t;

    // Returns 1 when the received parity bit does not match the selected sense.
    function automatic logic parity_bad(input logic [31:0] bits,
                                        input logic        pbit,
                                        input logic        odd);
        return ((^bits) ^ pbit) != odd;
    endfunction

endpackage

// File: rtl/uart_brk_rx_sync.sv
module uart_brk_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= {q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/uart_brk_rx_frame.sv
module uart_brk_rx_frame
    import uart_brk_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              line,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output rx_status_t        status
);
    localparam int PH_W      = $clog2(OSR);
    localparam int BIT_W     = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int SAMPLE_PH = OSR / 2 - 1;

    rx_state_e         state;
    logic [PH_W-1:0]   ph;
    logic [BIT_W-1:0]  bitn;
    logic [DATA_W-1:0] shreg;
    logic              pbit;
    logic              mid;

    assign mid = (ph == PH_W'(SAMPLE_PH));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_WAIT_HI;
            ph    <= '0;
            bitn  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
        end else if (tick) begin
            if (state != ST_WAIT_HI && state != ST_IDLE)
                ph <= (ph == PH_W'(OSR - 1)) ? '0 : ph + PH_W'(1);
            case (state)
                ST_WAIT_HI: if (line) state <= ST_IDLE;
                ST_IDLE: begin
                    if (!line) begin
                        state <= ST_START;
                        ph    <= PH_W'(1);
                    end
                end
                ST_START: begin
                    if (mid) begin
                        if (line) begin
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_DATA;
                            bitn  <= '0;
                        end
                    end
                end
                ST_DATA: begin
                    if (mid) begin
                        shreg <= {line, shreg[DATA_W-1:1]};
                        if (bitn == BIT_W'(DATA_W - 1))
                            state <= par_en ? ST_PAR : ST_STOP;
                        else
                            bitn <= bitn + BIT_W'(1);
                    end
                end
                ST_PAR: begin
                    if (mid) begin
                        pbit  <= line;
                        state <= ST_STOP;
                    end
                end
                ST_STOP: if (mid) state <= ST_WAIT_HI;
                default: state <= ST_WAIT_HI;
            endcase
        end
    end

    assign done        = tick && (state == ST_STOP) && mid;
    assign data        = shreg;
    assign status.ferr = !line;
    assign status.perr = par_en && parity_bad(32'(shreg), pbit, par_odd);
endmodule

// File: rtl/uart_brk_rx_flags.sv
module uart_brk_rx_flags
    import uart_brk_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [DATA_W-1:0] data,
    input  rx_status_t        status,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              frame_err,
    output logic              parity_err
);
    logic load;
    assign load = done && !status.ferr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            frame_err  <= 1'b0;
            parity_err <= 1'b0;
        end else begin
            rx_valid <= load;
            if (load) rx_data <= data;
            frame_err  <= (done && status.ferr) || (frame_err  && !err_clr);
            parity_err <= (done && status.perr) || (parity_err && !err_clr);
        end
    end
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
    import uart_brk_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              rxd,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              frame_err,
    output logic              parity_err,
    output logic              rxd_level
);
    logic              line;
    logic              done;
    logic [DATA_W-1:0] fr_data;
    rx_status_t        fr_status;

    uart_brk_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .din (rxd),
        .dout(line)
    );

    uart_brk_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) frame_i (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick16),
        .line   (line),
        .par_en (par_en),
        .par_odd(par_odd),
        .done   (done),
        .data   (fr_data),
        .status (fr_status)
    );

    uart_brk_rx_flags #(.DATA_W(DATA_W)) flags_i (
        .clk       (clk),
        .rst       (rst),
        .done      (done),
        .data      (fr_data),
        .status    (fr_status),
        .err_clr   (err_clr),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .frame_err (frame_err),
        .parity_err(parity_err)
    );

    assign rxd_level = line;
endmodule

// File: rtl/uart_brk_rx_chk.sv
module uart_brk_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rxd,
    input logic              err_clr,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              frame_err,
    input logic              parity_err,
    input logic              rxd_level
);
    // R2: the valid strobe lasts one clock
    a_r2_valid_single: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R4: a framing error never comes with a data load
    a_r4_fe_no_valid: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_err) |-> !rx_valid);

    // R4: the data register changes only together with the strobe
    a_r4_data_only_on_valid: assert property (@(posedge clk) disable iff (rst)
        (rx_data != $past(rx_data)) |-> rx_valid);

    // R7: flags hold while no clear is given
    a_r7_fe_sticky: assert property (@(posedge clk) disable iff (rst)
        (frame_err && !err_clr) |=> frame_err);
    a_r7_pe_sticky: assert property (@(posedge clk) disable iff (rst)
        (parity_err && !err_clr) |=> parity_err);

    // R6: line level is the input delayed by two clocks
    a_r6_level_delay: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 1) && !$past(rst, 2)) |-> (rxd_level == $past(rxd, 2)));
endmodule

bind uart_brk_rx uart_brk_rx_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/uart_brk_rx_tb_top.sv
module uart_brk_rx_tb_top;
    localparam int BIT_CLKS = 64;   // 16 ticks, one tick every 4 clocks

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, frame_err, parity_err, rxd_level;

    int  checks = 0;
    int  errors = 0;
    int  vcnt = 0;
    logic pe_seen = 1'b0;
    logic [1:0] tcnt = '0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        tcnt   <= tcnt + 2'd1;
        tick16 <= (tcnt == 2'd3);
        if (!rst && rx_valid) vcnt <= vcnt + 1;
        if (!rst && parity_err) pe_seen <= 1'b1;
    end

    uart_brk_rx dut_i (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .par_en(par_en), .par_odd(par_odd), .err_clr(err_clr),
        .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err),
        .parity_err(parity_err), .rxd_level(rxd_level)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic good_parity(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    task automatic hold(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clr_pulse();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic pe, input logic odd,
                        input logic bad_par, input logic bad_stop);
        par_en = pe; par_odd = odd;
        @(negedge clk); rxd = 1'b0; hold(BIT_CLKS);
        for (int b = 0; b < 8; b++) begin rxd = d[b]; hold(BIT_CLKS); end
        if (pe) begin rxd = good_parity(d, odd) ^ bad_par; hold(BIT_CLKS); end
        rxd = !bad_stop; hold(BIT_CLKS);
        rxd = 1'b1; hold(BIT_CLKS);
    endtask

    task automatic frame_case(input logic [7:0] d, input logic pe, input logic odd,
                              input logic bad_par, input logic bad_stop);
        int v0; logic [7:0] old;
        clr_pulse();
        v0 = vcnt; old = rx_data;
        send(d, pe, odd, bad_par, bad_stop);
        check("R2 valid count", vcnt - v0, bad_stop ? 0 : 1);
        check(bad_stop ? "R4 data kept" : "R2 data", rx_data, bad_stop ? old : d);
        check("R4 frame_err", frame_err, bad_stop);
        check("R3 parity_err", parity_err, pe && bad_par);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        hold(5);
        check("R1 valid", rx_valid, 0);
        check("R1 data", rx_data, 0);
        check("R1 flags", {frame_err, parity_err}, 0);
        check("R1 level", rxd_level, 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {rx_valid, frame_err, parity_err}, 0);
        hold(BIT_CLKS);

        // directed frames
        frame_case(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0);               // R2
        frame_case(8'h01, 1'b1, 1'b0, 1'b0, 1'b0);               // R3 even ok
        frame_case(8'h03, 1'b1, 1'b1, 1'b1, 1'b0);               // R3 odd bad
        frame_case(8'h7E, 1'b0, 1'b0, 1'b0, 1'b1);               // R4

        // R7 sticky: error frame, then clean frame without clear
        frame_case(8'h55, 1'b1, 1'b0, 1'b1, 1'b0);
        send(8'h12, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R7 parity_err held", parity_err, 1);
        clr_pulse();
        check("R7 cleared", parity_err, 0);

        // R7 set and clear in the same cycle
        pe_seen = 1'b0;
        @(negedge clk); err_clr = 1'b1;
        send(8'h3C, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R7 set wins over clear", pe_seen, 1);
        check("R7 clear after set", parity_err, 0);
        err_clr = 1'b0;

        // R8 false start: 4 ticks low then high
        begin
            int v0; v0 = vcnt;
            @(negedge clk); rxd = 1'b0; hold(16); rxd = 1'b1;
            hold(BIT_CLKS * 12);
            check("R8 no valid", vcnt - v0, 0);
            check("R8 no flags", {frame_err, parity_err}, 0);
        end

        // R5/R6 break with odd parity
        begin
            int v0; logic [7:0] old;
            v0 = vcnt; old = rx_data;
            par_en = 1'b1; par_odd = 1'b1;
            @(negedge clk); rxd = 1'b0;
            @(posedge clk); @(negedge clk);
            check("R6 level one clock", rxd_level, 1);
            @(posedge clk); @(negedge clk);
            check("R6 level two clocks", rxd_level, 0);
            hold(BIT_CLKS * 13);
            check("R5 frame_err", frame_err, 1);
            check("R5 parity_err odd", parity_err, 1);
            check("R6 level in break", rxd_level, 0);
            clr_pulse();
            hold(BIT_CLKS * 14);
            check("R5 no second frame", frame_err, 0);
            check("R5 no valid", vcnt - v0, 0);
            check("R5 data kept", rx_data, old);
            rxd = 1'b1; hold(BIT_CLKS);
        end
        // R5 break with even parity: no parity error
        par_en = 1'b1; par_odd = 1'b0;
        @(negedge clk); rxd = 1'b0; hold(BIT_CLKS * 13);
        check("R5 frame_err even", frame_err, 1);
        check("R5 parity_err even", parity_err, 0);
        rxd = 1'b1; hold(BIT_CLKS);
        frame_case(8'hC3, 1'b1, 1'b0, 1'b0, 1'b0);               // R9

        // random frames
        for (int n = 0; n < 24; n++) begin
            logic [7:0] d; logic pe, odd, bp, bs;
            d   = 8'($urandom);
            pe  = 1'($urandom);
            odd = 1'($urandom);
            bp  = ($urandom % 4) == 0;
            bs  = ($urandom % 5) == 0;
            frame_case(d, pe, odd, bp, bs);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule